// File: doc/BRIEF.md
# I2C Subaddressed 16-bit Register Bridge

This block is an I2C target that gives a host on the two-wire bus access to a bank of 16-bit registers. Those registers belong to an internal controller that sits next to the block. The host first sends one subaddress byte, which picks either a register write or a register read. It then sends a 16-bit register address, high byte first. For a write, two data bytes follow, high byte first. For a read, the host issues a repeated START, addresses the device for reading, and clocks out two data bytes, high byte first.

Toward the controller the block presents a single request port with a valid/ready handshake. The block raises the request and then holds SCL low for as long as the controller leaves it waiting. This pauses the bus until the controller has accepted the write or supplied the read data. The SCL and SDA inputs are synchronized to the system clock. Both outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_regbridge`

## Requirements
- R1: While reset is asserted, scl_oe, sda_oe and ctl_valid are all 0.
- R2: The target acknowledges a device address byte only when its upper 7 bits equal 7'b1000101, where bit 0 is the direction (0 = write, 1 = read). Any other address gets no acknowledge, and the transfer has no effect on the request port.
- R3: After a write-direction address, subaddress 8'h12 (register write) and 8'h13 (register read) are acknowledged. Every other value is answered with NAK and leads to no request.
- R4: A write transfer carries the register address in two bytes and then the data in two bytes, high byte first in both cases. It issues exactly one request with ctl_write=1, ctl_addr and ctl_wdata. That request is raised only after the acknowledge of the second data byte.
- R5: While ctl_valid is 1 and ctl_ready is 0, scl_oe holds SCL low. SCL is released once the handshake completes.
- R6: A read works as follows. Subaddress 8'h13 and the two address bytes come first. Then a repeated START and a read-direction address follow. This raises one request with ctl_write=0 and the same address, with SCL stretched until ready. The target then acknowledges and shifts out ctl_rdata, captured at the handshake, high byte first and MSB first.
- R7: When the host answers the second read byte with NAK, the target stops driving SDA.
- R8: A STOP, or a START before a write has completed its last data byte, aborts the transfer and issues no request. After a STOP, SDA is released.
- R9: A read-direction address that does not directly follow a completed read-subaddress setup gets NAK and raises no request.
- R10: While a request waits for ready, ctl_valid, ctl_write, ctl_addr and ctl_wdata stay unchanged.
- R11: The target changes its SDA drive only while SCL is low, so it never produces a START or STOP itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| ctl_valid | output | 1 | Request to the controller is pending |
| ctl_ready | input | 1 | Controller accepts the request this cycle |
| ctl_write | output | 1 | 1 = register write, 0 = register read |
| ctl_addr | output | 16 | Register address |
| ctl_wdata | output | 16 | Write data |
| ctl_rdata | input | 16 | Read data, sampled when ctl_valid and ctl_ready |

## Verification
The hardest situation to reach from the pins is the read request. It appears only after a full write-direction setup, a repeated START with no STOP before it, and a read-direction address. At that point the target stretches the ACK clock itself. The bench host models open-drain wiring and waits on the real SCL level whenever it raises the clock. The controller model delays ready by a different number of cycles on each transfer. Together these carry the bench through that sequence with stretches both short and long. Aborts are reached by cutting a write off with a STOP or a restart after the first data byte.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RACK, PH_RREQ, PH_TX, PH_TACK, PH_WREQ
  } phase_t;

  typedef enum logic [2:0] {
    BY_DEV, BY_SUB, BY_AH, BY_AL, BY_DH, BY_DL
  } bytepos_t;

  typedef enum logic [1:0] {SK_NONE, SK_WR, SK_RD} subkind_t;

  function automatic logic dev_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic subkind_t sub_kind(input logic [7:0] b,
                                        input logic [7:0] wcode,
                                        input logic [7:0] rcode);
    if (b == wcode) return SK_WR;
    if (b == rcode) return SK_RD;
    return SK_NONE;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= (g == 0) ? scl_i : scl_q[(g == 0) ? 0 : g - 1];
          sda_q[g] <= (g == 0) ? sda_i : sda_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rb_shift.sv
module i2c_rb_shift import i2c_rb_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              clr,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              sda_s,
  output logic [BYTE_W-1:0] byte_q,
  output logic [3:0]        cnt,
  output logic              tx_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cnt    <= '0;
    end else if (load) begin
      byte_q <= load_val;
      cnt    <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (rx_en) begin
      byte_q <= {byte_q[BYTE_W-2:0], sda_s};
      cnt    <= cnt + 4'd1;
    end else if (tx_en) begin
      byte_q <= {byte_q[BYTE_W-2:0], 1'b0};
      cnt    <= cnt + 4'd1;
    end
  end

  assign tx_bit = byte_q[BYTE_W-1];
endmodule

// File: rtl/i2c_rb_seq.sv
module i2c_rb_seq import i2c_rb_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h45,
  parameter logic [7:0] SUB_WR   = 8'h12,
  parameter logic [7:0] SUB_RD   = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] sh_byte,
  input  logic [3:0]        sh_cnt,
  input  logic              sh_bit,
  output logic              sh_clr,
  output logic              sh_rx,
  output logic              sh_tx,
  output logic              sh_load,
  output logic [BYTE_W-1:0] sh_val,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              ctl_valid,
  output logic              ctl_write,
  output logic [REG_W-1:0]  ctl_addr,
  output logic [REG_W-1:0]  ctl_wdata,
  input  logic              ctl_ready,
  input  logic [REG_W-1:0]  ctl_rdata
);
  phase_t   phase;
  bytepos_t pos;
  logic     ack_ok, wr_kind, rd_armed, rd_xfer, tx_second, host_ack;
  logic [REG_W-1:0] addr_q, wdata_q, rdata_q;

  logic req_phase, rx_full, bus_evt_ok;
  assign req_phase  = (phase == PH_RREQ) || (phase == PH_WREQ);
  assign rx_full    = (sh_cnt == 4'd8);
  assign bus_evt_ok = !req_phase;

  // shifter control
  assign sh_load = ((phase == PH_RACK) && scl_fall && ack_ok && rd_xfer) ||
                   ((phase == PH_TACK) && scl_fall && host_ack && !tx_second);
  assign sh_val  = (phase == PH_RACK) ? rdata_q[REG_W-1:BYTE_W] : rdata_q[BYTE_W-1:0];
  assign sh_clr  = start_det || ((phase == PH_RACK) && scl_fall);
  assign sh_rx   = (phase == PH_RX) && scl_rise && !rx_full;
  assign sh_tx   = (phase == PH_TX) && scl_fall;

  // bus and request outputs
  assign sda_oe    = ((phase == PH_RACK) && ack_ok) || (phase == PH_RREQ) ||
                     ((phase == PH_TX) && !sh_bit);
  assign scl_oe    = req_phase;
  assign ctl_valid = req_phase;
  assign ctl_write = (phase == PH_WREQ);
  assign ctl_addr  = addr_q;
  assign ctl_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pos       <= BY_DEV;
      ack_ok    <= 1'b0;
      wr_kind   <= 1'b0;
      rd_armed  <= 1'b0;
      rd_xfer   <= 1'b0;
      tx_second <= 1'b0;
      host_ack  <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else if (stop_det && bus_evt_ok) begin
      phase    <= PH_IDLE;
      rd_armed <= 1'b0;
      rd_xfer  <= 1'b0;
    end else if (start_det && bus_evt_ok) begin
      phase   <= PH_RX;
      pos     <= BY_DEV;
      rd_xfer <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: if (scl_fall && rx_full) begin
          phase  <= PH_RACK;
          ack_ok <= 1'b1;
          unique case (pos)
            BY_DEV: begin
              rd_armed <= 1'b0;
              if (!dev_hit(sh_byte, DEV_ADDR)) ack_ok <= 1'b0;
              else if (sh_byte[0]) begin
                if (rd_armed) begin
                  phase   <= PH_RREQ;
                  rd_xfer <= 1'b1;
                end else ack_ok <= 1'b0;
              end
            end
            BY_SUB: begin
              ack_ok  <= sub_kind(sh_byte, SUB_WR, SUB_RD) != SK_NONE;
              wr_kind <= sub_kind(sh_byte, SUB_WR, SUB_RD) == SK_WR;
            end
            BY_AH: addr_q[REG_W-1:BYTE_W] <= sh_byte;
            BY_AL: begin
              addr_q[BYTE_W-1:0] <= sh_byte;
              rd_armed           <= !wr_kind;
            end
            BY_DH: begin
              wdata_q[REG_W-1:BYTE_W] <= sh_byte;
              ack_ok                  <= wr_kind;
              rd_armed                <= 1'b0;
            end
            default: wdata_q[BYTE_W-1:0] <= sh_byte;
          endcase
        end
        PH_RACK: if (scl_fall) begin
          if (!ack_ok) phase <= PH_IDLE;
          else if (rd_xfer) begin
            phase     <= PH_TX;
            tx_second <= 1'b0;
          end else if (pos == BY_DL) phase <= PH_WREQ;
          else begin
            pos   <= bytepos_t'(pos + 3'd1);
            phase <= PH_RX;
          end
        end
        PH_RREQ: if (ctl_ready) begin
          rdata_q <= ctl_rdata;
          ack_ok  <= 1'b1;
          phase   <= PH_RACK;
        end
        PH_TX: if (scl_fall && sh_cnt == 4'd7) phase <= PH_TACK;
        PH_TACK: begin
          if (scl_rise) host_ack <= !sda_s;
          if (scl_fall) begin
            if (host_ack && !tx_second) begin
              phase     <= PH_TX;
              tx_second <= 1'b1;
            end else phase <= PH_IDLE;
          end
        end
        PH_WREQ: if (ctl_ready) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbridge.sv
module i2c_regbridge import i2c_rb_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h45,
  parameter logic [7:0] SUB_WR      = 8'h12,
  parameter logic [7:0] SUB_RD      = 8'h13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             ctl_valid,
  input  logic             ctl_ready,
  output logic             ctl_write,
  output logic [REG_W-1:0] ctl_addr,
  output logic [REG_W-1:0] ctl_wdata,
  input  logic [REG_W-1:0] ctl_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic sh_clr, sh_rx, sh_tx, sh_load, sh_bit;
  logic [BYTE_W-1:0] sh_val, sh_byte;
  logic [3:0] sh_cnt;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rb_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .clr(sh_clr), .rx_en(sh_rx), .tx_en(sh_tx), .sda_s(sda_s),
    .byte_q(sh_byte), .cnt(sh_cnt), .tx_bit(sh_bit)
  );

  i2c_rb_seq #(.DEV_ADDR(DEV_ADDR), .SUB_WR(SUB_WR), .SUB_RD(SUB_RD)) u_seq (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .sh_byte(sh_byte), .sh_cnt(sh_cnt), .sh_bit(sh_bit),
    .sh_clr(sh_clr), .sh_rx(sh_rx), .sh_tx(sh_tx), .sh_load(sh_load),
    .sh_val(sh_val), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .ctl_valid(ctl_valid), .ctl_write(ctl_write), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_ready(ctl_ready), .ctl_rdata(ctl_rdata)
  );
endmodule

// File: rtl/i2c_regbridge_chk.sv
module i2c_regbridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        ctl_valid,
  input logic        ctl_ready,
  input logic        ctl_write,
  input logic [15:0] ctl_addr,
  input logic [15:0] ctl_wdata,
  input logic        stop_det
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!scl_oe && !sda_oe && !ctl_valid);

  // R5
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && !ctl_ready |-> scl_oe);

  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_write) &&
                                $stable(ctl_addr) && $stable(ctl_wdata));

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe && !ctl_valid);
endmodule

bind i2c_regbridge i2c_regbridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_write(ctl_write),
  .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .stop_det(stop_det)
);

// File: tb/sim_i2c_regbridge.sv
`timescale 1ns/1ps
module sim_i2c_regbridge;
  localparam int H = 10;
  localparam logic [6:0] DEV = 7'b1000101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hscl = 1'b1, hsda = 1'b1;
  logic scl_oe, sda_oe, ctl_valid, ctl_ready, ctl_write;
  logic [15:0] ctl_addr, ctl_wdata, ctl_rdata;
  logic scl_i, sda_i;

  int n_chk = 0, n_err = 0, n_req = 0, wait_cnt = 0, ctl_delay = 0, stretch = 0;
  logic lw;
  logic [15:0] la, ld;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_i = hscl & ~scl_oe;
  assign sda_i = hsda & ~sda_oe;

  function automatic logic [15:0] rd_of(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  assign ctl_rdata = rd_of(ctl_addr);
  assign ctl_ready = ctl_valid && (wait_cnt >= ctl_delay);

  always @(posedge clk) begin
    if (ctl_valid && !ctl_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (ctl_valid && ctl_ready) begin
      n_req <= n_req + 1;
      lw <= ctl_write;
      la <= ctl_addr;
      ld <= ctl_wdata;
    end
  end

  i2c_regbridge u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_valid(ctl_valid),
    .ctl_ready(ctl_ready), .ctl_write(ctl_write), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    int c = 0;
    hscl = 1'b1;
    @(negedge clk);
    while (!scl_i && c < 5000) begin c++; @(negedge clk); end
    if (c > stretch) stretch = c;
  endtask

  task automatic bus_start();
    hsda = 1'b1; wt(H); scl_up(); wt(H);
    hsda = 1'b0; wt(H); hscl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    hsda = 1'b0; wt(H); scl_up(); wt(H); hsda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hsda = b[i]; wt(H); scl_up(); wt(H); hscl = 1'b0;
    end
    hsda = 1'b1; wt(H); scl_up(); wt(H/2);
    acked = !sda_i;
    wt(H/2); hscl = 1'b0;
  endtask

  task automatic recv_byte(input bit nak, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hsda = 1'b1; wt(H); scl_up(); wt(H/2);
      b[i] = sda_i;
      wt(H/2); hscl = 1'b0;
    end
    hsda = nak; wt(H); scl_up(); wt(H); hscl = 1'b0; wt(H);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, output int acks);
    bit k;
    acks = 0;
    bus_start();
    send_byte({DEV, 1'b0}, k); acks += k;
    send_byte(8'h12, k);       acks += k;
    send_byte(a[15:8], k);     acks += k;
    send_byte(a[7:0], k);      acks += k;
    send_byte(d[15:8], k);     acks += k;
    send_byte(d[7:0], k);      acks += k;
    bus_stop();
    wt(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int acks, base;
    bit k;
    logic [7:0] hb, lb;
    wt(5);
    // R1 reset state
    chk("R1", "scl_oe in reset", scl_oe, 0);
    chk("R1", "sda_oe in reset", sda_oe, 0);
    chk("R1", "ctl_valid in reset", ctl_valid, 0);
    rst_n = 1'b1;
    wt(10);

    // R4 R5 writes with varying controller delay
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a, d;
      a = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 16'h2B71);
      d = (i == 1) ? 16'hFFFF : 16'(~a ^ 16'(i << 4));
      ctl_delay = i * 9;
      stretch = 0;
      base = n_req;
      do_write(a, d, acks);
      chk("R4", "write acks", acks, 6);
      chk("R4", "write req count", n_req - base, 1);
      chk("R4", "write flag", lw, 1);
      chk("R4", "write addr", la, a);
      chk("R4", "write data", ld, d);
      if (ctl_delay >= 20) chk("R5", "write stretch long", int'(stretch >= ctl_delay - 12), 1);
    end

    // R6 R7 reads
    for (int i = 0; i < 5; i++) begin
      logic [15:0] a;
      a = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 16'h4D93 + 7);
      ctl_delay = i * 11;
      base = n_req;
      acks = 0;
      bus_start();
      send_byte({DEV, 1'b0}, k); acks += k;
      send_byte(8'h13, k);       acks += k;
      send_byte(a[15:8], k);     acks += k;
      send_byte(a[7:0], k);      acks += k;
      bus_start();
      stretch = 0;
      send_byte({DEV, 1'b1}, k); acks += k;
      if (ctl_delay >= 20) chk("R6", "read stretch long", int'(stretch >= ctl_delay - 12), 1);
      recv_byte(1'b0, hb);
      recv_byte(1'b1, lb);
      chk("R7", "sda released after host NAK", sda_oe, 0);
      bus_stop();
      wt(4);
      chk("R6", "read acks", acks, 5);
      chk("R6", "read req count", n_req - base, 1);
      chk("R6", "read flag", lw, 0);
      chk("R6", "read addr", la, a);
      chk("R6", "read data", {hb, lb}, rd_of(a));
    end

    // R2 device address sweep
    ctl_delay = 0;
    base = n_req;
    for (int v = 0; v < 128; v++) begin
      bus_start();
      send_byte({7'(v), 1'b0}, k);
      bus_stop();
      if (7'(v) != DEV) chk("R2", $sformatf("addr %0h ack", v), k, 0);
      else chk("R2", "own addr ack", k, 1);
    end
    chk("R2", "no req from address sweep", n_req - base, 0);

    // R3 subaddress sweep
    base = n_req;
    for (int s = 0; s < 64; s++) begin
      logic [7:0] sb;
      sb = (s < 48) ? 8'(s) : 8'(8'hF0 + s - 48);
      bus_start();
      send_byte({DEV, 1'b0}, k);
      send_byte(sb, k);
      bus_stop();
      chk("R3", $sformatf("sub %0h ack", sb), k, int'(sb == 8'h12 || sb == 8'h13));
    end
    chk("R3", "no req from sub sweep", n_req - base, 0);

    // R8 abort by STOP after first data byte
    base = n_req;
    bus_start();
    send_byte({DEV, 1'b0}, k); send_byte(8'h12, k);
    send_byte(8'hA1, k); send_byte(8'hB2, k); send_byte(8'hC3, k);
    bus_stop();
    wt(4);
    chk("R8", "no req after stop abort", n_req - base, 0);
    chk("R8", "sda released after stop", sda_oe, 0);

    // R8 abort by restart, then a full write
    bus_start();
    send_byte({DEV, 1'b0}, k); send_byte(8'h12, k);
    send_byte(8'h55, k); send_byte(8'h66, k); send_byte(8'h77, k);
    bus_start();
    send_byte({DEV, 1'b0}, k); send_byte(8'h12, k);
    send_byte(8'h0F, k); send_byte(8'hF0, k); send_byte(8'h12, k); send_byte(8'h34, k);
    bus_stop();
    wt(4);
    chk("R8", "one req after restart", n_req - base, 1);
    chk("R8", "restart write addr", la, 16'h0FF0);
    chk("R8", "restart write data", ld, 16'h1234);

    // R9 read address without setup
    base = n_req;
    bus_start();
    send_byte({DEV, 1'b1}, k);
    bus_stop();
    chk("R9", "unarmed read ack", k, 0);
    chk("R9", "no req unarmed read", n_req - base, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule